// File: doc/BRIEF.md
# PCI Even-Parity Generator and Checker

This block produces and verifies the even-parity bit that accompanies the multiplexed address/data lanes and the command/byte-enable lanes of a PCI-style bus agent. When the agent drives an address or a data phase, the block computes a parity bit over both lane groups. It presents that bit, with its output enable, in the clock that follows the phase. When the agent receives a phase, the block keeps the parity it computed from the sampled lanes. In the next clock it compares that value with the sampled parity pin. It reports any mismatch one clock after that comparison.

Mismatches in an address phase go to an open-drain style system-error output. Mismatches in a completed data transfer go to a driven, active-low parity-error output, which follows sustained tri-state rules. Each output is gated by enable bits that the surrounding logic copies from the command register. Two single-clock status pulses tell that logic when to set its detected-parity-error and signalled-system-error status bits. Bus ownership, tri-state pads and the register storage itself live outside this block.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_o` makes the total count of ones across `ad_i`, `cbe_i` and the parity bit even, so it equals the XOR of all address/data and command/byte-enable bits that were present.
- R2: `par_oe_o` is 1 in exactly the clock after a clock where `drv_addr_i` or `drv_data_i` was 1. In that clock, `par_o` covers the lanes of that earlier clock.
- R3: For a phase received in clock N, `par_i` is compared in clock N+1, and any error output or status pulse caused by it appears in clock N+2.
- R4: An address-phase mismatch drives `serr_n_o` low with `serr_oe_o` high for one clock, but only if `serr_en_i` and `perr_resp_en_i` were both 1 in the compare clock. In every other clock, `serr_oe_o` is 0 and `serr_n_o` is 1.
- R5: A data-phase mismatch drives `perr_n_o` low with `perr_oe_o` high, but only if `perr_resp_en_i` was 1 in the compare clock. `serr_en_i` has no effect on this output.
- R6: `dpe_pulse_o` is 1 for one clock for every address or data mismatch, whatever the enable bits are. `sse_pulse_o` is 1 in exactly the clocks where `serr_n_o` is driven low.
- R7: A data phase is checked only if `rx_data_i` was 1 and both active-low ready inputs `irdy_n_i` and `trdy_n_i` were 0 in the same clock. Otherwise the phase never causes a parity-error output or a status pulse.
- R8: After the last clock where `perr_n_o` is driven low, `perr_oe_o` stays 1 with `perr_n_o` at 1 for one more clock. It then falls to 0 unless a new error is reported.
- R9: While `rst_n` is 0, all three output enables and both status pulses are 0, and both active-low error outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | AD_W | Address/data lanes as driven or sampled this clock |
| cbe_i | input | BE_W | Command/byte-enable lanes, active low as on the bus |
| par_i | input | 1 | Sampled parity pin |
| drv_addr_i | input | 1 | This agent drives an address phase this clock |
| drv_data_i | input | 1 | This agent drives write or read data this clock |
| rx_addr_i | input | 1 | An address phase is on the bus for this agent to check |
| rx_data_i | input | 1 | This agent is the data receiver this clock |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| perr_resp_en_i | input | 1 | Parity error response enable from the command register |
| serr_en_i | input | 1 | System error enable from the command register |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity pin |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Output enable for the data parity error pin |
| serr_n_o | output | 1 | System error, active low |
| serr_oe_o | output | 1 | Open-drain pull-down enable for system error |
| dpe_pulse_o | output | 1 | Detected-parity-error status set pulse |
| sse_pulse_o | output | 1 | Signalled-system-error status set pulse |

## Verification
The bench builds the block with an 8-bit address/data width, one byte-enable lane and the explicit XOR tree. With this configuration, all 512 lane combinations can be driven, so every input pattern reaches the generated parity. The same 512 values are also received under each of the four enable combinations. Faults are injected on a fixed stride, and the ready-signal pairs rotate, so the bench covers gated and ungated data phases, back-to-back parity-error clocks and the release clock after them. The expected values come from a bench-side XOR of the lanes and a two-clock history of the applied stimulus.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

   // Kind of phase captured for checking
   typedef struct packed {
      logic addr;
      logic data;
   } rx_kind_t;

   // Mismatch report handed from the checker to the report stage
   typedef struct packed {
      logic addr_mis;
      logic data_mis;
   } mis_t;

   localparam int unsigned PAR_LAG = 1;   // parity after lanes
   localparam int unsigned ERR_LAG = 2;   // strobe after lanes

   function automatic int unsigned tree_levels(input int unsigned width);
      int unsigned lv;
      lv = 0;
      while ((1 << lv) < width) lv++;
      if (lv == 0) lv = 1;
      return lv;
   endfunction

endpackage

// File: rtl/pci_par_xor_tree.sv
module pci_par_xor_tree #(
   parameter int unsigned W        = 36,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [W-1:0] lanes_i,
   output logic         par_o
);
   import pci_par_pkg::*;

   localparam int unsigned LVLS = tree_levels(W);
   localparam int unsigned NP   = 1 << LVLS;

   generate
      if (W < 2) begin : g_bad_width
         $error("pci_par_xor_tree: W must be at least 2");
      end

      if (USE_TREE) begin : g_tree
         for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
            logic [(NP >> l)-1:0] v;
            if (l == 0) begin : g_leaf
               assign v = NP'(lanes_i);
            end else begin : g_node
               for (genvar i = 0; i < (NP >> l); i++) begin : g_x
                  assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
               end
            end
         end
         assign par_o = g_lvl[LVLS].v[0];
      end else begin : g_flat
         assign par_o = ^lanes_i;
      end
   endgenerate

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic calc_i,
   input  logic drive_i,
   output logic par_o,
   output logic par_oe_o
);

   logic par_q;
   logic oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         par_q <= calc_i;
         oe_q  <= drive_i;
      end
   end

   assign par_o    = par_q;
   assign par_oe_o = oe_q;

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
   import pci_par_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     calc_i,
   input  rx_kind_t kind_i,
   input  logic     par_i,
   output mis_t     mis_o
);

   logic     calc_q;
   rx_kind_t kind_q;
   logic     differ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         calc_q <= 1'b0;
         kind_q <= '0;
      end else begin
         calc_q <= calc_i;
         kind_q <= kind_i;
      end
   end

   assign differ         = calc_q ^ par_i;
   assign mis_o.addr_mis = kind_q.addr & differ;
   assign mis_o.data_mis = kind_q.data & differ;

endmodule

// File: rtl/pci_par_report.sv
module pci_par_report
   import pci_par_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  mis_t mis_i,
   input  logic perr_resp_en_i,
   input  logic serr_en_i,
   output logic perr_n_o,
   output logic perr_oe_o,
   output logic serr_n_o,
   output logic serr_oe_o,
   output logic dpe_pulse_o,
   output logic sse_pulse_o
);

   logic perr_n_q, perr_oe_q, serr_drv_q, dpe_q;
   logic perr_low, serr_drv;

   assign perr_low = mis_i.data_mis & perr_resp_en_i;
   assign serr_drv = mis_i.addr_mis & perr_resp_en_i & serr_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_n_q   <= 1'b1;
         perr_oe_q  <= 1'b0;
         serr_drv_q <= 1'b0;
         dpe_q      <= 1'b0;
      end else begin
         perr_n_q   <= ~perr_low;
         perr_oe_q  <= perr_low | ~perr_n_q;
         serr_drv_q <= serr_drv;
         dpe_q      <= mis_i.addr_mis | mis_i.data_mis;
      end
   end

   assign perr_n_o    = perr_n_q;
   assign perr_oe_o   = perr_oe_q;
   assign serr_n_o    = ~serr_drv_q;
   assign serr_oe_o   = serr_drv_q;
   assign sse_pulse_o = serr_drv_q;
   assign dpe_pulse_o = dpe_q;

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
   parameter int unsigned AD_W     = 32,
   parameter int unsigned BE_W     = 4,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AD_W-1:0] ad_i,
   input  logic [BE_W-1:0] cbe_i,
   input  logic            par_i,
   input  logic            drv_addr_i,
   input  logic            drv_data_i,
   input  logic            rx_addr_i,
   input  logic            rx_data_i,
   input  logic            irdy_n_i,
   input  logic            trdy_n_i,
   input  logic            perr_resp_en_i,
   input  logic            serr_en_i,
   output logic            par_o,
   output logic            par_oe_o,
   output logic            perr_n_o,
   output logic            perr_oe_o,
   output logic            serr_n_o,
   output logic            serr_oe_o,
   output logic            dpe_pulse_o,
   output logic            sse_pulse_o
);
   import pci_par_pkg::*;

   localparam int unsigned LANES = AD_W + BE_W;

   generate
      if (AD_W % 8 != 0) begin : g_bad_ad
         $error("pci_parity_unit: AD_W must be a whole number of bytes");
      end
      if (BE_W != AD_W / 8) begin : g_bad_be
         $error("pci_parity_unit: BE_W must be one lane per byte");
      end
   endgenerate

   logic [LANES-1:0] lanes;
   logic             calc;
   rx_kind_t         kind;
   mis_t             mis;

   assign lanes     = {cbe_i, ad_i};
   assign kind.addr = rx_addr_i;
   assign kind.data = rx_data_i & ~irdy_n_i & ~trdy_n_i;

   pci_par_xor_tree #(.W(LANES), .USE_TREE(USE_TREE)) i_tree (
      .lanes_i (lanes),
      .par_o   (calc)
   );

   pci_par_gen i_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .calc_i   (calc),
      .drive_i  (drv_addr_i | drv_data_i),
      .par_o    (par_o),
      .par_oe_o (par_oe_o)
   );

   pci_par_chk i_chk (
      .clk    (clk),
      .rst_n  (rst_n),
      .calc_i (calc),
      .kind_i (kind),
      .par_i  (par_i),
      .mis_o  (mis)
   );

   pci_par_report i_rep (
      .clk            (clk),
      .rst_n          (rst_n),
      .mis_i          (mis),
      .perr_resp_en_i (perr_resp_en_i),
      .serr_en_i      (serr_en_i),
      .perr_n_o       (perr_n_o),
      .perr_oe_o      (perr_oe_o),
      .serr_n_o       (serr_n_o),
      .serr_oe_o      (serr_oe_o),
      .dpe_pulse_o    (dpe_pulse_o),
      .sse_pulse_o    (sse_pulse_o)
   );

endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
   parameter int unsigned AD_W = 32,
   parameter int unsigned BE_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AD_W-1:0] ad_i,
   input logic [BE_W-1:0] cbe_i,
   input logic            drv_addr_i,
   input logic            drv_data_i,
   input logic            perr_resp_en_i,
   input logic            serr_en_i,
   input logic            par_o,
   input logic            par_oe_o,
   input logic            perr_n_o,
   input logic            perr_oe_o,
   input logic            serr_n_o,
   input logic            serr_oe_o,
   input logic            dpe_pulse_o,
   input logic            sse_pulse_o
);

   // R1 R2: parity follows driven lanes by one clock
   a_r2_par_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_addr_i || drv_data_i) |=> (par_oe_o && par_o == $past(^{cbe_i, ad_i})));

   a_r2_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_addr_i || drv_data_i) |=> !par_oe_o);

   // R4: system error gated by both enables and open-drain shaped
   a_r4_serr_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> (serr_oe_o && $past(serr_en_i) && $past(perr_resp_en_i)));

   a_r4_serr_od: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> !serr_n_o);

   // R5: parity error requires response enable
   a_r5_perr_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> (perr_oe_o && $past(perr_resp_en_i)));

   // R6: signalled system error is always also a detected error
   a_r6_sse_dpe: assert property (@(posedge clk) disable iff (!rst_n)
      sse_pulse_o |-> (dpe_pulse_o && !serr_n_o));

   a_r6_perr_dpe: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> dpe_pulse_o);

   // R8: parity error pin released only after a high clock
   a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perr_oe_o) |-> $past(perr_n_o));

   a_r8_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perr_n_o) |-> perr_oe_o);

endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .BE_W(BE_W)) i_pci_parity_unit_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ad_i           (ad_i),
   .cbe_i          (cbe_i),
   .drv_addr_i     (drv_addr_i),
   .drv_data_i     (drv_data_i),
   .perr_resp_en_i (perr_resp_en_i),
   .serr_en_i      (serr_en_i),
   .par_o          (par_o),
   .par_oe_o       (par_oe_o),
   .perr_n_o       (perr_n_o),
   .perr_oe_o      (perr_oe_o),
   .serr_n_o       (serr_n_o),
   .serr_oe_o      (serr_oe_o),
   .dpe_pulse_o    (dpe_pulse_o),
   .sse_pulse_o    (sse_pulse_o)
);

// File: tb/test_pci_parity_unit.sv
`timescale 1ns/1ps
module test_pci_parity_unit;

   localparam int AD_W = 8;
   localparam int BE_W = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AD_W-1:0] ad = '0;
   logic [BE_W-1:0] cbe = '0;
   logic            par_in = 1'b0;
   logic            da = 1'b0, dd = 1'b0, ra = 1'b0, rd = 1'b0;
   logic            irdy_n = 1'b1, trdy_n = 1'b1;
   logic            pen = 1'b0, sen = 1'b0;
   logic            par_o, par_oe_o, perr_n_o, perr_oe_o, serr_n_o, serr_oe_o;
   logic            dpe_pulse_o, sse_pulse_o;

   int total = 0;
   int bad = 0;

   // bench history
   logic [AD_W+BE_W-1:0] prev_lanes = '0;
   logic prev_addr = 1'b0, prev_data = 1'b0, last_perr_low = 1'b0;

   always #10 clk = ~clk;

   pci_parity_unit #(.AD_W(AD_W), .BE_W(BE_W), .USE_TREE(1'b1)) i_pci_parity_unit (
      .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .par_i(par_in),
      .drv_addr_i(da), .drv_data_i(dd), .rx_addr_i(ra), .rx_data_i(rd),
      .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .perr_resp_en_i(pen), .serr_en_i(sen),
      .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
      .serr_n_o(serr_n_o), .serr_oe_o(serr_oe_o),
      .dpe_pulse_o(dpe_pulse_o), .sse_pulse_o(sse_pulse_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic even_par(input logic [AD_W+BE_W-1:0] v);
      logic p;
      p = 1'b0;
      for (int i = 0; i < AD_W + BE_W; i++) p ^= v[i];
      return p;
   endfunction

   // Apply one clock of stimulus, then check all outputs after the edge
   task automatic step(input logic [AD_W+BE_W-1:0] lanes, input logic a_drv, input logic d_drv,
                       input logic a_rx, input logic d_rx, input logic ir, input logic tr,
                       input logic p);
      logic mis, amis, dmis, exp_serr, exp_perr_low;
      ad = lanes[AD_W-1:0]; cbe = lanes[AD_W+BE_W-1:AD_W];
      da = a_drv; dd = d_drv; ra = a_rx; rd = d_rx; irdy_n = ir; trdy_n = tr; par_in = p;
      @(posedge clk);
      #5;
      mis  = (even_par(prev_lanes) != p);
      amis = prev_addr & mis;
      dmis = prev_data & mis;
      exp_serr     = amis & pen & sen;
      exp_perr_low = dmis & pen;
      check("R1 par_o", par_o & (a_drv | d_drv), even_par(lanes) & (a_drv | d_drv));
      check("R2 par_oe_o", par_oe_o, a_drv | d_drv);
      check("R3 R6 dpe_pulse_o", dpe_pulse_o, amis | dmis);
      check("R4 serr_n_o", serr_n_o, ~exp_serr);
      check("R4 serr_oe_o", serr_oe_o, exp_serr);
      check("R6 sse_pulse_o", sse_pulse_o, exp_serr);
      check("R5 R7 perr_n_o", perr_n_o, ~exp_perr_low);
      check("R8 perr_oe_o", perr_oe_o, exp_perr_low | last_perr_low);
      last_perr_low = exp_perr_low;
      prev_lanes = lanes;
      prev_addr  = a_rx;
      prev_data  = d_rx & ~ir & ~tr;
      #5;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      // R9: reset state
      repeat (3) @(posedge clk);
      #5;
      check("R9 par_oe_o", par_oe_o, 1'b0);
      check("R9 perr_oe_o", perr_oe_o, 1'b0);
      check("R9 serr_oe_o", serr_oe_o, 1'b0);
      check("R9 perr_n_o", perr_n_o, 1'b1);
      check("R9 serr_n_o", serr_n_o, 1'b1);
      check("R9 dpe_pulse_o", dpe_pulse_o, 1'b0);
      check("R9 sse_pulse_o", sse_pulse_o, 1'b0);
      #5;
      rst_n = 1'b1;

      // R1 R2: exhaustive driven sweep with idle gaps
      for (int v = 0; v < 512; v++)
         step(9'(v), (v % 3) == 0, (v % 3) == 1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

      // R3..R8: received sweep under every enable combination
      for (int e = 0; e < 4; e++) begin
         pen = e[0]; sen = e[1];
         for (int v = 0; v < 512; v++) begin
            logic [1:0] rdy;
            logic p;
            rdy = 2'((v >> 1) % 4);
            p = even_par(prev_lanes) ^ ((v % 5) == 0);
            step(9'((v * 37 + e) % 512), 1'b0, 1'b0, (v % 2) == 0, (v % 2) == 1,
                 rdy[0], rdy[1], p);
         end
         step('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, even_par(prev_lanes));
         step('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      end

      // R8: back-to-back data errors, then release
      pen = 1'b1; sen = 1'b0;
      for (int k = 0; k < 4; k++)
         step(9'(k + 3), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ~even_par(prev_lanes));
      for (int k = 0; k < 4; k++)
         step('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ~even_par(prev_lanes));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule